// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Access Engine

This block lets a processor reach a serial NOR flash through ordinary memory loads and stores. It serves a small number of chip selects. Each one has its own control word, which holds an access mode, a command byte and a software "stop" bit that keeps that chip-select line released. A window access is a bus read or write naming a chip select, a byte address and a length of 1 to 4 bytes. In the three direct modes the engine turns that access into a complete flash transaction. It asserts the line, shifts out the command, the address and an optional dummy byte, moves the data, then releases the line and waits one idle serial clock before it acknowledges.

In user mode the window becomes a raw byte pipe. No command or address is generated and the chip-select line is whatever software last wrote into the stop bit. This lets firmware issue any flash command by hand, such as erase, status polling or ID reads.

The controller is a single state machine with the states ST_IDLE, ST_DECODE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_GAP and ST_DONE. Its transitions are:
- ST_IDLE goes to ST_DECODE when win_valid is seen, and latches the request.
- ST_DECODE goes to ST_DONE when the access is refused, to ST_DATA in user mode, and to ST_CMD otherwise.
- ST_CMD goes to ST_ADDR.
- ST_ADDR stays in ST_ADDR for each further address byte. After the last one it goes to ST_DUMMY in fast read and to ST_DATA in the other modes.
- ST_DUMMY goes to ST_DATA.
- ST_DATA stays in ST_DATA for each further byte. After the last byte it goes to ST_GAP in the direct modes and to ST_DONE in user mode.
- ST_GAP goes to ST_DONE after one serial clock period.
- ST_DONE always goes to ST_IDLE.

A byte shifter and a register file sit under the controller.

Top module: `sfl_engine`

## Requirements
- R1: After reset every chip-select line is high. Register 0 (configuration) reads 0x00000002, which is flash type SPI (value 2) in field [1:0] for CE0. Register 1 (wide addressing) reads 0x1. Register 2 (divider) reads 1. Each control register (index 4+cs) reads 0x4. win_ready is low.
- R2: Control bits [1:0] select the mode: 0 normal read, 1 fast read, 2 write, 3 user. A read in normal read mode sends 0x03 whatever bits [23:16] hold. It then sends the address most significant byte first and captures the data.
- R3: A read in fast read mode sends the command from control bits [23:16], then the address, then one 0x00 dummy byte, then captures the data.
- R4: When bit cs of register 1 is set, the address phase for that chip select is 4 bytes and starts with bits 31:24. Otherwise it is 3 bytes starting with bits 23:16.
- R5: Register 8+cs bits [4:0] give log2 of the segment size. The address is masked to that size before it is sent. An address with bits outside the segment sets win_err, but the transaction still runs with the masked address.
- R6: Data is little-endian. The first data byte on the wire maps to bits 7:0. win_len is the byte count minus one.
- R7: A write in write mode sends the command, the address and the data bytes. It is only carried out when configuration bit 16+cs is set.
- R8: A write to a chip select whose enable bit 16+cs is clear produces no serial activity. The access completes with win_err set.
- R9: A read in write mode, a write in either read mode, and an access to a nonexistent chip select all produce no serial activity. Each completes with win_err set.
- R10: A zero command byte in fast read or write mode sets win_err, but the transaction is still sent with command 0x00.
- R11: In user mode the line follows control bit 2 (1 = released). A read shifts out 0x00 filler bytes and returns the captured bytes. A write shifts out the data bytes. Neither generates a command or an address.
- R12: The serial interface uses SPI mode 0, MSB first. SCLK is idle low and has a period of 2*(register 2 bits [7:0] + 1) clocks.
- R13: At the end of a direct transaction the stop bit of that chip select reads 1. The line stays high for at least one SCLK period before win_ready.
- R14: win_ready is a single-cycle completion pulse, and win_rdata and win_err are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| win_valid | input | 1 | Window access request, held until win_ready |
| win_write | input | 1 | 1 = write, 0 = read |
| win_cs | input | CSW | Chip-select index |
| win_addr | input | 32 | Byte address within the segment |
| win_len | input | 2 | Byte count minus one |
| win_wdata | input | 32 | Write data, little-endian |
| win_ready | output | 1 | Completion pulse |
| win_rdata | output | 32 | Read data |
| win_err | output | 1 | Error flag for the completed access |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip-select lines |

## Verification
The hardest state to reach is a control word whose stop bit is 0 in a direct mode. That asserts the line before the access starts, and only the end-of-transaction release puts it back to 1. The bench writes such a word, runs a read and then reads the bit back. The other hard case is the error path that still transmits, where the segment mask and a zero command must both flag and still run. The bench reaches it by shrinking the segment register and clearing the command field. It then compares every byte on the serial line against a frame computed from the request.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    typedef enum logic [1:0] {
        MD_READ  = 2'd0,
        MD_FAST  = 2'd1,
        MD_WRITE = 2'd2,
        MD_USER  = 2'd3
    } md_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_GAP,
        ST_DONE
    } st_e;

    localparam logic [3:0] REG_CFG   = 4'd0;
    localparam logic [3:0] REG_WIDE  = 4'd1;
    localparam logic [3:0] REG_DIV   = 4'd2;
    localparam logic [3:0] REG_CTRL0 = 4'd4;
    localparam logic [3:0] REG_SEG0  = 4'd8;

    localparam logic [7:0] OP_SLOW_READ = 8'h03;
    localparam int         WE_BASE      = 16;
    localparam logic [1:0] TYPE_SPI     = 2'd2;

endpackage

// File: rtl/sfl_regs.sv
module sfl_regs
    import sfl_pkg::*;
#(
    parameter int NCS     = 2,
    parameter int SEG_RST = 24,
    parameter int DIV_RST = 1,
    localparam int CSW    = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wen,
    input  logic [3:0]               addr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    input  logic                     rel_v,
    input  logic [CSW-1:0]           rel_cs,
    output logic [NCS-1:0][1:0]      mode_o,
    output logic [NCS-1:0][7:0]      cmd_o,
    output logic [NCS-1:0]           stop_o,
    output logic [NCS-1:0]           wen_o,
    output logic [NCS-1:0]           wide_o,
    output logic [NCS-1:0][4:0]      seg_o,
    output logic [7:0]               half_o
);

    logic [31:0]            cfg_q;
    logic [NCS-1:0]         wide_q;
    logic [7:0]             div_q;
    logic [NCS-1:0][31:0]   ctrl_q;
    logic [NCS-1:0][4:0]    seg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= 32'({TYPE_SPI});
            div_q <= 8'(DIV_RST);
        end else if (wen && addr == REG_CFG) begin
            cfg_q <= wdata;
        end else if (wen && addr == REG_DIV) begin
            div_q <= wdata[7:0];
        end
    end

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wide_q[i] <= (i == 0);
            end else if (wen && addr == REG_WIDE) begin
                wide_q[i] <= wdata[i];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[i] <= 32'h4;
            end else if (wen && addr == 4'(REG_CTRL0 + i)) begin
                ctrl_q[i] <= wdata;
            end else if (rel_v && int'(rel_cs) == i) begin
                ctrl_q[i][2] <= 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_q[i] <= 5'(SEG_RST);
            end else if (wen && addr == 4'(REG_SEG0 + i)) begin
                seg_q[i] <= wdata[4:0];
            end
        end

        assign mode_o[i] = ctrl_q[i][1:0];
        assign cmd_o[i]  = ctrl_q[i][23:16];
        assign stop_o[i] = ctrl_q[i][2];
        assign wen_o[i]  = cfg_q[WE_BASE + i];
        assign wide_o[i] = wide_q[i];
        assign seg_o[i]  = seg_q[i];

        // R13: a release request leaves the stop bit set unless software wrote it
        assert_release_sets_stop_R13: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_v && int'(rel_cs) == i && !(wen && addr == 4'(REG_CTRL0 + i)))
            |=> stop_o[i]);
    end

    assign half_o = div_q;

    always_comb begin
        rdata = '0;
        if (addr == REG_CFG)       rdata = cfg_q;
        else if (addr == REG_WIDE) rdata[NCS-1:0] = wide_q;
        else if (addr == REG_DIV)  rdata[7:0] = div_q;
        for (int i = 0; i < NCS; i++) begin
            if (addr == 4'(REG_CTRL0 + i)) rdata = ctrl_q[i];
            if (addr == 4'(REG_SEG0 + i))  rdata = {27'd0, seg_q[i]};
        end
    end

endmodule

// File: rtl/sfl_shifter.sv
module sfl_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic [7:0] half,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi
);

    logic [7:0] sh_q;
    logic [7:0] rx_q;
    logic [7:0] cnt_q;
    logic [7:0] half_q;
    logic [2:0] bit_q;
    logic       sclk_q;
    logic       busy_q;
    logic       done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            rx_q   <= '0;
            cnt_q  <= '0;
            half_q <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                sh_q   <= tx;
                cnt_q  <= '0;
                bit_q  <= '0;
                sclk_q <= 1'b0;
                half_q <= half;
            end else if (busy_q) begin
                if (cnt_q == half_q) begin
                    cnt_q  <= '0;
                    sclk_q <= ~sclk_q;
                    if (!sclk_q) begin
                        rx_q <= {rx_q[6:0], miso};
                    end else if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end else begin
                    cnt_q <= cnt_q + 8'd1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign rx   = rx_q;
    assign sclk = sclk_q;
    assign mosi = busy_q & sh_q[7];

    assert_sclk_idle_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q);

    assert_mosi_steady_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(mosi));

endmodule

// File: rtl/sfl_engine.sv
module sfl_engine
    import sfl_pkg::*;
#(
    parameter int NCS     = 2,
    parameter int SEG_RST = 24,
    parameter int DIV_RST = 1,
    localparam int CSW    = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wen,
    input  logic [3:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            win_valid,
    input  logic            win_write,
    input  logic [CSW-1:0]  win_cs,
    input  logic [31:0]     win_addr,
    input  logic [1:0]      win_len,
    input  logic [31:0]     win_wdata,
    output logic            win_ready,
    output logic [31:0]     win_rdata,
    output logic            win_err,
    output logic            spi_sclk,
    output logic            spi_mosi,
    input  logic            spi_miso,
    output logic [NCS-1:0]  spi_cs_n
);

    logic [NCS-1:0][1:0] mode_w;
    logic [NCS-1:0][7:0] cmd_w;
    logic [NCS-1:0]      stop_w;
    logic [NCS-1:0]      we_w;
    logic [NCS-1:0]      wide_w;
    logic [NCS-1:0][4:0] seg_w;
    logic [7:0]          half_w;

    st_e            state_q, state_d;
    logic           rq_wr;
    logic [CSW-1:0] rq_cs;
    logic [31:0]    rq_addr;
    logic [1:0]     rq_len;
    logic [31:0]    rq_wdata;
    md_e            rq_md;
    logic [7:0]     rq_cmd;
    logic [7:0]     rq_half;
    logic           err_q;
    logic [1:0]     bidx_q;
    logic [31:0]    rdata_q;
    logic [8:0]     gap_q;

    logic           sh_start, sh_busy, sh_done;
    logic [7:0]     sh_tx, sh_rx;
    logic           rel_v;
    logic           drive;

    // decode terms
    logic           cs_ok;
    logic [CSW-1:0] cs_i;
    md_e            md_now;
    logic [7:0]     cmd_now;
    logic [31:0]    seg_mask;
    logic           dir_ok, refused, seg_err, zero_err;

    sfl_regs #(.NCS(NCS), .SEG_RST(SEG_RST), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .rel_v(rel_v), .rel_cs(rq_cs),
        .mode_o(mode_w), .cmd_o(cmd_w), .stop_o(stop_w), .wen_o(we_w),
        .wide_o(wide_w), .seg_o(seg_w), .half_o(half_w)
    );

    sfl_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(sh_start), .tx(sh_tx), .half(rq_half), .miso(spi_miso),
        .busy(sh_busy), .done(sh_done), .rx(sh_rx),
        .sclk(spi_sclk), .mosi(spi_mosi)
    );

    always_comb begin
        cs_ok    = int'(rq_cs) < NCS;
        cs_i     = cs_ok ? rq_cs : '0;
        md_now   = md_e'(mode_w[cs_i]);
        cmd_now  = (md_now == MD_READ) ? OP_SLOW_READ : cmd_w[cs_i];
        seg_mask = (32'd1 << seg_w[cs_i]) - 32'd1;
        dir_ok   = rq_wr ? (md_now == MD_WRITE || md_now == MD_USER)
                         : (md_now != MD_WRITE);
        refused  = !cs_ok || !dir_ok || (rq_wr && !we_w[cs_i]);
        seg_err  = |(rq_addr & ~seg_mask);
        zero_err = (md_now == MD_FAST || md_now == MD_WRITE) && cmd_now == 8'h00;
    end

    // state register and request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rq_wr    <= 1'b0;
            rq_cs    <= '0;
            rq_addr  <= '0;
            rq_len   <= '0;
            rq_wdata <= '0;
            rq_md    <= MD_READ;
            rq_cmd   <= '0;
            rq_half  <= '0;
            err_q    <= 1'b0;
            bidx_q   <= '0;
            rdata_q  <= '0;
            gap_q    <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (win_valid) begin
                    rq_wr    <= win_write;
                    rq_cs    <= win_cs;
                    rq_addr  <= win_addr;
                    rq_len   <= win_len;
                    rq_wdata <= win_wdata;
                    rdata_q  <= '0;
                    err_q    <= 1'b0;
                end
                ST_DECODE: begin
                    rq_md   <= md_now;
                    rq_cmd  <= cmd_now;
                    rq_half <= half_w;
                    rq_addr <= rq_addr & seg_mask;
                    bidx_q  <= (md_now == MD_USER) ? 2'd0 : (wide_w[cs_i] ? 2'd3 : 2'd2);
                    err_q   <= refused || (md_now != MD_USER && (seg_err || zero_err));
                end
                ST_CMD: ;
                ST_ADDR: if (sh_done) begin
                    bidx_q <= (bidx_q == 2'd0) ? 2'd0 : bidx_q - 2'd1;
                end
                ST_DUMMY: ;
                ST_DATA: if (sh_done) begin
                    rdata_q[{bidx_q, 3'b000} +: 8] <= sh_rx;
                    bidx_q <= bidx_q + 2'd1;
                    gap_q  <= '0;
                end
                ST_GAP: gap_q <= gap_q + 9'd1;
                ST_DONE: ;
            endcase
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_valid) state_d = ST_DECODE;
            ST_DECODE: begin
                if (refused)                  state_d = ST_DONE;
                else if (md_now == MD_USER)   state_d = ST_DATA;
                else                          state_d = ST_CMD;
            end
            ST_CMD:    if (sh_done) state_d = ST_ADDR;
            ST_ADDR:   if (sh_done && bidx_q == 2'd0)
                           state_d = (rq_md == MD_FAST) ? ST_DUMMY : ST_DATA;
            ST_DUMMY:  if (sh_done) state_d = ST_DATA;
            ST_DATA:   if (sh_done && bidx_q == rq_len)
                           state_d = (rq_md == MD_USER) ? ST_DONE : ST_GAP;
            ST_GAP:    if (gap_q == {rq_half, 1'b1}) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sh_tx = 8'h00;
        unique case (state_q)
            ST_CMD:  sh_tx = rq_cmd;
            ST_ADDR: sh_tx = rq_addr[{bidx_q, 3'b000} +: 8];
            ST_DATA: sh_tx = rq_wr ? rq_wdata[{bidx_q, 3'b000} +: 8] : 8'h00;
            default: sh_tx = 8'h00;
        endcase
        sh_start = (state_q == ST_CMD || state_q == ST_ADDR || state_q == ST_DUMMY ||
                    state_q == ST_DATA) && !sh_busy && !sh_done;
        drive    = (state_q == ST_CMD || state_q == ST_ADDR || state_q == ST_DUMMY ||
                    state_q == ST_DATA) && rq_md != MD_USER;
        rel_v    = state_q == ST_DATA && sh_done && bidx_q == rq_len && rq_md != MD_USER;
        for (int i = 0; i < NCS; i++) begin
            spi_cs_n[i] = stop_w[i] & ~(drive && int'(rq_cs) == i);
        end
        win_ready = state_q == ST_DONE;
        win_err   = state_q == ST_DONE && err_q;
        win_rdata = rdata_q;
    end

    assert_ready_single_R14: assert property (@(posedge clk) disable iff (!rst_n)
        win_ready |=> !win_ready);

    assert_gap_released_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> spi_cs_n[cs_i]);

    assert_refused_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && refused) |=> !sh_busy && state_q == ST_DONE);

    assert_data_after_shifter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && sh_done) |=> $stable(rq_addr));

endmodule

// File: tb/sfl_engine_test.sv
module sfl_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        win_valid = 1'b0;
    logic        win_write = 1'b0;
    logic [0:0]  win_cs = '0;
    logic [31:0] win_addr = '0;
    logic [1:0]  win_len = '0;
    logic [31:0] win_wdata = '0;
    logic        win_ready;
    logic [31:0] win_rdata;
    logic        win_err;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [NCS-1:0] spi_cs_n;

    int checks = 0;
    int fails  = 0;

    sfl_engine #(.NCS(NCS)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .win_valid(win_valid), .win_write(win_write), .win_cs(win_cs), .win_addr(win_addr),
        .win_len(win_len), .win_wdata(win_wdata), .win_ready(win_ready),
        .win_rdata(win_rdata), .win_err(win_err),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // flash model
    function automatic logic [7:0] reply(int j);
        return 8'(8'h3C + j * 37);
    endfunction

    wire  cs_act = ~&spi_cs_n;
    logic [7:0] frame [0:31];
    int   m_nbytes = 0;
    int   m_bits = 0;
    int   m_frames = 0;
    logic [7:0] m_sh = '0;
    time  t_e0 = 0, t_e1 = 0, t_rise = 0;

    assign spi_miso = cs_act ? reply(m_nbytes)[3'(7 - m_bits)] : 1'b0;

    always @(posedge cs_act) begin
        m_nbytes = 0;
        m_bits   = 0;
        m_frames = m_frames + 1;
    end
    always @(negedge cs_act) t_rise = $time;
    always @(posedge spi_sclk) if (cs_act) begin
        if (m_nbytes == 0 && m_bits == 0) t_e0 = $time;
        if (m_nbytes == 0 && m_bits == 1) t_e1 = $time;
        m_sh   = {m_sh[6:0], spi_mosi};
        m_bits = m_bits + 1;
        if (m_bits == 8) begin
            if (m_nbytes < 32) frame[m_nbytes] = m_sh;
            m_nbytes = m_nbytes + 1;
            m_bits   = 0;
        end
    end

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic win_access(logic wr, logic [0:0] cs, logic [31:0] a, logic [1:0] len,
                              logic [31:0] wd, output logic [31:0] rd, output logic er);
        @(negedge clk);
        win_valid = 1'b1; win_write = wr; win_cs = cs; win_addr = a;
        win_len = len; win_wdata = wd;
        @(negedge clk);
        while (!win_ready) @(negedge clk);
        rd = win_rdata;
        er = win_err;
        win_valid = 1'b0;
    endtask

    function automatic logic [31:0] ctrlv(logic [1:0] md, logic [7:0] cmd, logic stop);
        return {8'h00, cmd, 13'h0000, stop, md};
    endfunction

    logic [7:0] exp_b [0:31];
    int exp_n;

    task automatic check_frame(string tag);
        check_eq(tag, 32'(m_nbytes), 32'(exp_n));
        for (int k = 0; k < exp_n && k < m_nbytes; k++)
            check_eq(tag, {24'd0, frame[k]}, {24'd0, exp_b[k]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, rd, exp_rd, a;
        logic er;
        int f0, k, j0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check_eq("R1 cs_n", {30'd0, spi_cs_n}, 32'h3);
        check_eq("R1 ready", {31'd0, win_ready}, 32'h0);
        reg_rd(4'd0, v); check_eq("R1 cfg", v, 32'h2);
        reg_rd(4'd1, v); check_eq("R1 wide", v, 32'h1);
        reg_rd(4'd2, v); check_eq("R1 div", v, 32'h1);
        reg_rd(4'd4, v); check_eq("R1 ctrl0", v, 32'h4);
        reg_rd(4'd5, v); check_eq("R1 ctrl1", v, 32'h4);

        reg_wr(4'd0, 32'h0003_0002);

        // direct-mode sweep: modes x cs x address width x length
        for (int md = 0; md < 3; md++)
            for (int cs = 0; cs < 2; cs++)
                for (int fb = 0; fb < 2; fb++)
                    for (int n = 1; n <= 4; n++) begin
                        logic [7:0] cmd;
                        logic [31:0] wd;
                        string tag;
                        cmd = (md == 0) ? 8'hAA : (md == 1) ? 8'h0B : 8'h02;
                        reg_wr(4'(4 + cs), ctrlv(2'(md), cmd, 1'b1));
                        reg_wr(4'd1, 32'(fb) << cs);
                        a  = 32'h0010_2030 + 32'(n) * 32'h0001_0101 + 32'(cs) * 32'h0004_0000;
                        wd = 32'hA1B2_C3D4 ^ (32'(n) << 8);
                        f0 = m_frames;
                        win_access(md == 2, 1'(cs), a, 2'(n - 1), wd, rd, er);
                        tag = (md == 2) ? "R7" : fb ? "R4" : (md == 1) ? "R3" : "R2";
                        k = 0;
                        exp_b[k++] = (md == 0) ? 8'h03 : cmd;
                        if (fb) exp_b[k++] = a[31:24];
                        exp_b[k++] = a[23:16];
                        exp_b[k++] = a[15:8];
                        exp_b[k++] = a[7:0];
                        if (md == 1) exp_b[k++] = 8'h00;
                        j0 = k;
                        exp_rd = '0;
                        for (int b = 0; b < n; b++) begin
                            exp_b[k++] = (md == 2) ? wd[8*b +: 8] : 8'h00;
                            exp_rd[8*b +: 8] = reply(j0 + b);
                        end
                        exp_n = k;
                        check_eq(tag, 32'(m_frames - f0), 32'd1);
                        check_frame(tag);
                        if (md != 2) check_eq("R6 rdata", rd, exp_rd);
                        check_eq("R14 err", {31'd0, er}, 32'd0);
                        check_eq("R13 cs_n", {30'd0, spi_cs_n}, 32'h3);
                        reg_rd(4'(4 + cs), v);
                        check_eq("R13 stop", {31'd0, v[2]}, 32'd1);
                    end

        // R5 segment masking
        reg_wr(4'd1, 32'h0);
        reg_wr(4'd8, 32'd12);
        reg_wr(4'd4, ctrlv(2'd0, 8'h00, 1'b1));
        win_access(1'b0, 1'b0, 32'h0001_2345, 2'd0, 0, rd, er);
        exp_b[0] = 8'h03; exp_b[1] = 8'h00; exp_b[2] = 8'h03; exp_b[3] = 8'h45; exp_b[4] = 8'h00;
        exp_n = 5;
        check_frame("R5");
        check_eq("R5 err", {31'd0, er}, 32'd1);
        check_eq("R5 rdata", rd, {24'd0, reply(4)});
        reg_wr(4'd8, 32'd24);

        // R4 top address byte through a full-width segment
        reg_wr(4'd9, 32'd31);
        reg_wr(4'd1, 32'h2);
        reg_wr(4'd5, ctrlv(2'd1, 8'h0C, 1'b1));
        win_access(1'b0, 1'b1, 32'h5A12_3456, 2'd0, 0, rd, er);
        exp_b[0] = 8'h0C; exp_b[1] = 8'h5A; exp_b[2] = 8'h12; exp_b[3] = 8'h34;
        exp_b[4] = 8'h56; exp_b[5] = 8'h00; exp_b[6] = 8'h00; exp_n = 7;
        check_frame("R4");
        check_eq("R4 err", {31'd0, er}, 32'd0);
        reg_wr(4'd1, 32'h0);

        // R8 write blocked by cleared enable
        reg_wr(4'd0, 32'h0001_0002);
        reg_wr(4'd5, ctrlv(2'd2, 8'h02, 1'b1));
        f0 = m_frames;
        win_access(1'b1, 1'b1, 32'h100, 2'd0, 32'h55, rd, er);
        check_eq("R8 frames", 32'(m_frames - f0), 32'd0);
        check_eq("R8 err", {31'd0, er}, 32'd1);
        reg_wr(4'd0, 32'h0003_0002);

        // R9 direction mismatches
        reg_wr(4'd4, ctrlv(2'd2, 8'h02, 1'b1));
        f0 = m_frames;
        win_access(1'b0, 1'b0, 32'h10, 2'd1, 0, rd, er);
        check_eq("R9 read-in-write err", {31'd0, er}, 32'd1);
        reg_wr(4'd4, ctrlv(2'd1, 8'h0B, 1'b1));
        win_access(1'b1, 1'b0, 32'h10, 2'd1, 32'h1234, rd, er);
        check_eq("R9 write-in-fast err", {31'd0, er}, 32'd1);
        reg_wr(4'd4, ctrlv(2'd0, 8'h0B, 1'b1));
        win_access(1'b1, 1'b0, 32'h10, 2'd1, 32'h1234, rd, er);
        check_eq("R9 write-in-read err", {31'd0, er}, 32'd1);
        check_eq("R9 frames", 32'(m_frames - f0), 32'd0);

        // R10 zero command still sent
        reg_wr(4'd4, ctrlv(2'd1, 8'h00, 1'b1));
        f0 = m_frames;
        win_access(1'b0, 1'b0, 32'h0000_0102, 2'd0, 0, rd, er);
        check_eq("R10 err", {31'd0, er}, 32'd1);
        check_eq("R10 frames", 32'(m_frames - f0), 32'd1);
        check_eq("R10 cmd", {24'd0, frame[0]}, 32'h0);
        check_eq("R10 len", 32'(m_nbytes), 32'd6);

        // R11 user mode pass-through
        reg_wr(4'd5, ctrlv(2'd3, 8'h00, 1'b0));
        check_eq("R11 cs low", {30'd0, spi_cs_n}, 32'h1);
        win_access(1'b0, 1'b1, 32'hFFFF_FFFF, 2'd1, 0, rd, er);
        check_eq("R11 rdata", rd, {16'd0, reply(1), reply(0)});
        check_eq("R11 err", {31'd0, er}, 32'd0);
        win_access(1'b1, 1'b1, 32'h0, 2'd1, 32'h0000_BEEF, rd, er);
        exp_b[0] = 8'h00; exp_b[1] = 8'h00; exp_b[2] = 8'hEF; exp_b[3] = 8'hBE; exp_n = 4;
        check_frame("R11");
        check_eq("R11 still low", {30'd0, spi_cs_n}, 32'h1);
        reg_wr(4'd5, ctrlv(2'd3, 8'h00, 1'b1));
        check_eq("R11 cs high", {30'd0, spi_cs_n}, 32'h3);

        // R12 and R13: slower divider, stop bit cleared before a direct read
        reg_wr(4'd2, 32'd3);
        reg_wr(4'd4, ctrlv(2'd0, 8'h00, 1'b0));
        check_eq("R13 pre-asserted", {30'd0, spi_cs_n}, 32'h2);
        win_access(1'b0, 1'b0, 32'h0000_0040, 2'd0, 0, rd, er);
        check_eq("R12 period", 32'((t_e1 - t_e0) / CLK_PERIOD), 32'd8);
        check_eq("R13 gap", {31'd0, ($time - t_rise) >= 8 * CLK_PERIOD}, 32'd1);
        reg_rd(4'd4, v);
        check_eq("R13 stop", {31'd0, v[2]}, 32'd1);
        check_eq("R13 cs_n", {30'd0, spi_cs_n}, 32'h3);
        check_eq("R2 rdata", rd, {24'd0, reply(4)});
        @(negedge clk);
        check_eq("R14 pulse", {31'd0, win_ready}, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule